// File: doc/BRIEF.md
# Banked Palette Look-Up Table

This block sits between the pixel fetch logic and the panel data formatter of an LCD controller. It receives a pixel value together with the current colour depth, a colour or monochrome flag, two bank-select bits and a display-enable bit. From these it produces three 4-bit drive values, one each for red, green and blue. There are three palette tables of 16 entries each, four bits wide. How the pixel indexes them depends on the depth. At the lowest depth the tables are bypassed and the output is pure black or white. At two bits the tables are cut into four banks of four. At four bits the pixel reaches all sixteen entries. At eight bits in colour the pixel splits into separate red, green and blue indices, and the bank bits pick part of each table.

Software fills the tables through a small two-register port. The address register holds a 4-bit entry pointer and a 2-bit component selector. The data register reads or writes the entry being pointed at. When the selector is zero the port steps through red, green and blue, then moves the pointer forward, so a whole palette can be loaded with one address write followed by a stream of data accesses.

Top module: `palette_lut`

## Requirements
- R1: While reset is high and in the cycle after it, the three colour outputs are zero. After reset every table entry reads zero and the address register reads zero.
- R2: At depth code 0 (one bit per pixel) the tables are not used, whatever the colour flag says. Pixel bit 0 equal to 0 gives green 0x0 and pixel bit 0 equal to 1 gives green 0xF. Red and blue are 0.
- R3: At depth code 1 (two bits per pixel) each table is indexed by {bank_sel[1:0], pix_in[1:0]}.
- R4: At depth code 2 (four bits per pixel) each table is indexed by pix_in[3:0], and bank_sel has no effect.
- R5: With color_en low, only the green table drives an output. Green carries the looked-up value and red and blue are 0. At depth code 3 in this mode the index is pix_in[3:0].
- R6: At depth code 3 with color_en high, the red index is {bank_sel[0], pix_in[7:5]}, the green index is {bank_sel[0], pix_in[4:2]} and the blue index is {bank_sel[1:0], pix_in[1:0]}.
- R7: When disp_on is low, all three outputs are 0 in the following cycle.
- R8: The outputs are registered. A pixel presented before a rising clock edge shows on the outputs just after that edge and not before it.
- R9: reg_sel=0 selects the address register: bits 3:0 are the entry pointer and bits 5:4 are the component (0 auto, 1 red, 2 green, 3 blue). It reads back as written. reg_sel=1 selects the data register: bits 3:0 hold the entry and a read returns 0 in bits 5:4.
- R10: With component 1, 2 or 3, a data write stores into that table at the pointer and a data read returns that entry. The pointer does not change.
- R11: With component 0, each data access (read or write) targets red, then green, then blue. After blue the pointer goes up by one, wrapping from 15 to 0. Writing the address register restarts the sequence at red.
- R12: CPU access reaches all 16 entries of every table, whatever the bank bits and depth are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 8 | Pixel value from display memory |
| depth | input | 2 | Bits per pixel: 0=1, 1=2, 2=4, 3=8 |
| color_en | input | 1 | 1 colour, 0 monochrome |
| bank_sel | input | 2 | Palette bank select |
| disp_on | input | 1 | Display enable; low blanks outputs |
| reg_sel | input | 1 | 0 address register, 1 data register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Register read data |
| red_o | output | 4 | Red drive value |
| grn_o | output | 4 | Green (or monochrome) drive value |
| blu_o | output | 4 | Blue drive value |

## Verification
The bench loads the tables in auto mode and ends the load at entry 15, so that the pointer has to wrap to 0. A design that fails to wrap, or that advances one access early, leaves the contents skewed across components, and the read-back catches this. It rewrites the address register in the middle of a triplet and then checks that the next write lands in red again rather than continuing to green. It also reads back every entry while bank 3 is selected, which catches banking that leaks into the CPU path. For the 3-3-2 split, it walks the bank bits in 8-bit mode, where a design using the wrong bank bit for red or green, or only one bank bit for blue, shows the wrong colour. Further checks cover the bypass at one bit per pixel with the colour flag set, blanking with the display off, and the single cycle of output latency.

// File: rtl/palette_pkg.sv
package palette_pkg;

    localparam int PIX_W = 8;
    localparam int ENT_W = 4;
    localparam int IDX_W = 4;
    localparam int N_ENT = 1 << IDX_W;
    localparam int N_TBL = 3;
    localparam int REG_W = 6;

    typedef enum logic [1:0] {
        DEPTH_1 = 2'd0,
        DEPTH_2 = 2'd1,
        DEPTH_4 = 2'd2,
        DEPTH_8 = 2'd3
    } depth_e;

    typedef enum logic [1:0] {
        COMP_AUTO = 2'd0,
        COMP_RED  = 2'd1,
        COMP_GRN  = 2'd2,
        COMP_BLU  = 2'd3
    } comp_e;

    typedef enum logic [1:0] {
        OUT_BW    = 2'd0,
        OUT_MONO  = 2'd1,
        OUT_COLOR = 2'd2
    } out_mode_e;

    typedef struct packed {
        logic [IDX_W-1:0] red;
        logic [IDX_W-1:0] grn;
        logic [IDX_W-1:0] blu;
    } idx_set_t;

    typedef struct packed {
        logic [ENT_W-1:0] red;
        logic [ENT_W-1:0] grn;
        logic [ENT_W-1:0] blu;
    } rgb_t;

    function automatic comp_e next_comp(comp_e c);
        case (c)
            COMP_RED: return COMP_GRN;
            COMP_GRN: return COMP_BLU;
            default:  return COMP_RED;
        endcase
    endfunction

    function automatic logic [1:0] tbl_of(comp_e c);
        case (c)
            COMP_GRN: return 2'd1;
            COMP_BLU: return 2'd2;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/pal_table.sv
module pal_table
    import palette_pkg::*;
#(
    parameter int AW = IDX_W,
    parameter int DW = ENT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cpu_q,
    input  logic [AW-1:0] disp_addr,
    output logic [DW-1:0] disp_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[cpu_addr] <= wdata;
        end
    end

    assign cpu_q  = mem[cpu_addr];
    assign disp_q = mem[disp_addr];

endmodule

// File: rtl/pal_cpu_port.sv
module pal_cpu_port
    import palette_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_sel,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [REG_W-1:0]            reg_wdata,
    input  logic [N_TBL-1:0][ENT_W-1:0] tbl_q,
    output logic [N_TBL-1:0]            tbl_we,
    output logic [IDX_W-1:0]            ptr,
    output logic [ENT_W-1:0]            wr_val,
    output logic [REG_W-1:0]            reg_rdata,
    output comp_e                       comp
);
    comp_e phase;
    comp_e target;
    logic  data_acc;

    assign target   = (comp == COMP_AUTO) ? phase : comp;
    assign data_acc = reg_sel && (reg_wr || reg_rd);
    assign wr_val   = reg_wdata[ENT_W-1:0];

    generate
        for (genvar g = 0; g < N_TBL; g++) begin : g_we
            assign tbl_we[g] = reg_sel && reg_wr && (tbl_of(target) == 2'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            comp  <= COMP_AUTO;
            phase <= COMP_RED;
        end else if (reg_wr && !reg_sel) begin
            ptr   <= reg_wdata[IDX_W-1:0];
            comp  <= comp_e'(reg_wdata[IDX_W+1:IDX_W]);
            phase <= COMP_RED;
        end else if (data_acc && comp == COMP_AUTO) begin
            phase <= next_comp(phase);
            if (phase == COMP_BLU) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    always_comb begin
        if (reg_sel) begin
            reg_rdata = {{(REG_W-ENT_W){1'b0}}, tbl_q[tbl_of(target)]};
        end else begin
            reg_rdata = {comp, ptr};
        end
    end

endmodule

// File: rtl/pal_index_map.sv
module pal_index_map
    import palette_pkg::*;
(
    input  logic [PIX_W-1:0] pix,
    input  depth_e           depth,
    input  logic             color_en,
    input  logic [1:0]       bank,
    output idx_set_t         idx,
    output out_mode_e        mode
);
    always_comb begin
        if (depth == DEPTH_1) begin
            mode = OUT_BW;
        end else if (!color_en) begin
            mode = OUT_MONO;
        end else begin
            mode = OUT_COLOR;
        end
    end

    always_comb begin
        idx = '0;
        case (depth)
            DEPTH_2: begin
                idx.red = {bank, pix[1:0]};
                idx.grn = {bank, pix[1:0]};
                idx.blu = {bank, pix[1:0]};
            end
            DEPTH_4: begin
                idx.red = pix[3:0];
                idx.grn = pix[3:0];
                idx.blu = pix[3:0];
            end
            DEPTH_8: begin
                if (color_en) begin
                    idx.red = {bank[0], pix[7:5]};
                    idx.grn = {bank[0], pix[4:2]};
                    idx.blu = {bank,    pix[1:0]};
                end else begin
                    idx.red = pix[3:0];
                    idx.grn = pix[3:0];
                    idx.blu = pix[3:0];
                end
            end
            default: idx = '0;
        endcase
    end

endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import palette_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix_in,
    input  logic [1:0]       depth,
    input  logic             color_en,
    input  logic [1:0]       bank_sel,
    input  logic             disp_on,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [ENT_W-1:0] red_o,
    output logic [ENT_W-1:0] grn_o,
    output logic [ENT_W-1:0] blu_o
);
    idx_set_t                    idx;
    out_mode_e                   mode;
    logic [N_TBL-1:0][IDX_W-1:0] disp_idx;
    logic [N_TBL-1:0][ENT_W-1:0] disp_q;
    logic [N_TBL-1:0][ENT_W-1:0] cpu_q;
    logic [N_TBL-1:0]            tbl_we;
    logic [IDX_W-1:0]            cur_addr;
    logic [ENT_W-1:0]            wr_val;
    comp_e                       cur_comp;
    rgb_t                        nxt;
    rgb_t                        out_q;

    pal_index_map u_map (
        .pix      (pix_in),
        .depth    (depth_e'(depth)),
        .color_en (color_en),
        .bank     (bank_sel),
        .idx      (idx),
        .mode     (mode)
    );

    pal_cpu_port u_cpu (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .tbl_q     (cpu_q),
        .tbl_we    (tbl_we),
        .ptr       (cur_addr),
        .wr_val    (wr_val),
        .reg_rdata (reg_rdata),
        .comp      (cur_comp)
    );

    assign disp_idx[0] = idx.red;
    assign disp_idx[1] = idx.grn;
    assign disp_idx[2] = idx.blu;

    generate
        for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
            pal_table #(.AW(IDX_W), .DW(ENT_W)) u_tbl (
                .clk       (clk),
                .rst       (rst),
                .we        (tbl_we[g]),
                .cpu_addr  (cur_addr),
                .wdata     (wr_val),
                .cpu_q     (cpu_q[g]),
                .disp_addr (disp_idx[g]),
                .disp_q    (disp_q[g])
            );
        end
    endgenerate

    always_comb begin
        nxt = '0;
        if (disp_on) begin
            case (mode)
                OUT_BW:    nxt.grn = {ENT_W{pix_in[0]}};
                OUT_MONO:  nxt.grn = disp_q[1];
                OUT_COLOR: begin
                    nxt.red = disp_q[0];
                    nxt.grn = disp_q[1];
                    nxt.blu = disp_q[2];
                end
                default:   nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= nxt;
        end
    end

    assign red_o = out_q.red;
    assign grn_o = out_q.grn;
    assign blu_o = out_q.blu;

endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk (
    input logic       clk,
    input logic       rst,
    input logic       disp_on,
    input logic [1:0] depth,
    input logic       color_en,
    input logic       pix_lsb,
    input logic       reg_sel,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [3:0] cur_addr,
    input logic [1:0] cur_comp,
    input logic [3:0] red_o,
    input logic [3:0] grn_o,
    input logic [3:0] blu_o
);
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (red_o == 4'h0 && grn_o == 4'h0 && blu_o == 4'h0));

    p_blank_off_r7: assert property (@(posedge clk) disable iff (rst)
        !disp_on |=> (red_o == 4'h0 && grn_o == 4'h0 && blu_o == 4'h0));

    p_mono_green_only_r5: assert property (@(posedge clk) disable iff (rst)
        (!color_en || depth == 2'd0) |=> (red_o == 4'h0 && blu_o == 4'h0));

    p_bw_levels_r2: assert property (@(posedge clk) disable iff (rst)
        (disp_on && depth == 2'd0) |=> (grn_o == {4{$past(pix_lsb)}}));

    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && (reg_wr || reg_rd) && cur_comp != 2'd0) |=> $stable(cur_addr));

    p_ptr_step_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && (reg_wr || reg_rd) && cur_comp == 2'd0)
        |=> (cur_addr == $past(cur_addr) || cur_addr == 4'($past(cur_addr) + 4'd1)));
endmodule

bind palette_lut pal_lut_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .disp_on  (disp_on),
    .depth    (depth),
    .color_en (color_en),
    .pix_lsb  (pix_in[0]),
    .reg_sel  (reg_sel),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .cur_addr (cur_addr),
    .cur_comp (cur_comp),
    .red_o    (red_o),
    .grn_o    (grn_o),
    .blu_o    (blu_o)
);

// File: tb/test_palette_lut.sv
module test_palette_lut;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix_in = '0;
    logic [1:0] depth = '0;
    logic       color_en = 1'b0;
    logic [1:0] bank_sel = '0;
    logic       disp_on = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [5:0] reg_wdata = '0;
    logic [5:0] reg_rdata;
    logic [3:0] red_o, grn_o, blu_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [3:0] m_tab [3][16];
    logic [3:0] m_addr = '0;
    logic [1:0] m_comp = '0;
    int         m_phase = 0;

    palette_lut i_palette_lut (
        .clk(clk), .rst(rst), .pix_in(pix_in), .depth(depth),
        .color_en(color_en), .bank_sel(bank_sel), .disp_on(disp_on),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int tgt_tbl();
        return (m_comp == 2'd0) ? m_phase : int'(m_comp) - 1;
    endfunction

    function automatic void model_step();
        if (m_comp == 2'd0) begin
            if (m_phase == 2) begin
                m_phase = 0;
                m_addr  = m_addr + 4'd1;
            end else begin
                m_phase++;
            end
        end
    endfunction

    task automatic reg_write(logic sel, logic [5:0] data);
        @(negedge clk);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = data;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        if (!sel) begin
            m_addr = data[3:0]; m_comp = data[5:4]; m_phase = 0;
        end else begin
            m_tab[tgt_tbl()][m_addr] = data[3:0];
            model_step();
        end
    endtask

    task automatic reg_check(string req, logic sel);
        logic [5:0] exp;
        logic [5:0] got;
        exp = sel ? {2'b00, m_tab[tgt_tbl()][m_addr]} : {m_comp, m_addr};
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 got = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0;
        if (sel) model_step();
        chk(req, 32'(got), 32'(exp));
    endtask

    function automatic logic [11:0] exp_rgb(logic [7:0] p, logic [1:0] d,
                                            logic c, logic [1:0] b, logic on);
        logic [3:0] ir, ig, ib;
        if (!on) return 12'h000;
        if (d == 2'd0) return {4'h0, p[0] ? 4'hF : 4'h0, 4'h0};
        case (d)
            2'd1:    begin ir = {b, p[1:0]}; ig = ir; ib = ir; end
            2'd2:    begin ir = p[3:0]; ig = ir; ib = ir; end
            default: begin
                if (c) begin
                    ir = {b[0], p[7:5]}; ig = {b[0], p[4:2]}; ib = {b, p[1:0]};
                end else begin
                    ir = p[3:0]; ig = ir; ib = ir;
                end
            end
        endcase
        if (!c) return {4'h0, m_tab[1][ig], 4'h0};
        return {m_tab[0][ir], m_tab[1][ig], m_tab[2][ib]};
    endfunction

    task automatic pix_step(string req, logic [7:0] p, logic [1:0] d,
                            logic c, logic [1:0] b, logic on);
        logic [11:0] exp;
        exp = exp_rgb(p, d, c, b, on);
        @(negedge clk);
        pix_in = p; depth = d; color_en = c; bank_sel = b; disp_on = on;
        @(negedge clk);
        chk(req, 32'({red_o, grn_o, blu_o}), 32'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int t = 0; t < 3; t++) for (int e = 0; e < 16; e++) m_tab[t][e] = 4'h0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b1; disp_on = 1'b1; depth = 2'd2; color_en = 1'b1;
        @(negedge clk);
        chk("R1 outputs in reset", 32'({red_o, grn_o, blu_o}), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", 32'({red_o, grn_o, blu_o}), 32'h0);
        reg_check("R1 address register", 1'b0);
        reg_write(1'b0, {2'd1, 4'd7});
        reg_check("R1 table entry zero", 1'b1);

        // auto-increment load of all 48 entries, ending with pointer wrap
        reg_write(1'b0, 6'h00);
        for (int i = 0; i < 48; i++) reg_write(1'b1, 6'($urandom_range(0, 15)));
        reg_check("R11 pointer wrapped to 0", 1'b0);
        for (int c = 1; c <= 3; c++) begin
            for (int a = 0; a < 16; a++) begin
                reg_write(1'b0, {2'(c), 4'(a)});
                reg_check("R11 auto-loaded entry", 1'b1);
            end
        end

        // direct mode write and read, pointer holds
        reg_write(1'b0, {2'd2, 4'd5});
        reg_write(1'b1, 6'h0A);
        reg_check("R10 direct green readback", 1'b1);
        reg_check("R10 direct read repeat", 1'b1);
        reg_check("R9 R10 address reg unchanged", 1'b0);

        // auto read across the wrap
        reg_write(1'b0, {2'd0, 4'd14});
        for (int i = 0; i < 6; i++) reg_check("R11 auto read sequence", 1'b1);
        reg_check("R11 pointer after auto reads", 1'b0);

        // restart in the middle of a triplet
        reg_write(1'b0, {2'd0, 4'd3});
        reg_write(1'b1, 6'h06);
        reg_write(1'b0, {2'd0, 4'd3});
        reg_write(1'b1, 6'h09);
        reg_write(1'b0, {2'd1, 4'd3});
        reg_check("R11 restart targets red", 1'b1);
        reg_write(1'b0, {2'd2, 4'd3});
        reg_check("R11 green untouched", 1'b1);

        // CPU access independent of banking
        @(negedge clk);
        depth = 2'd1; bank_sel = 2'd3; color_en = 1'b1; disp_on = 1'b1;
        reg_write(1'b0, {2'd3, 4'd1});
        reg_write(1'b1, 6'h0C);
        for (int a = 0; a < 16; a++) begin
            reg_write(1'b0, {2'd3, 4'(a)});
            reg_check("R12 blue entry under bank 3", 1'b1);
        end

        // directed display cases
        pix_step("R2 bw zero", 8'hFE, 2'd0, 1'b0, 2'd0, 1'b1);
        pix_step("R2 bw one", 8'h01, 2'd0, 1'b0, 2'd2, 1'b1);
        pix_step("R2 bw one with colour flag", 8'h01, 2'd0, 1'b1, 2'd1, 1'b1);
        for (int b = 0; b < 4; b++) begin
            for (int p = 0; p < 4; p++) begin
                pix_step("R3 two-bit banked colour", 8'(p) | 8'hF0, 2'd1, 1'b1, 2'(b), 1'b1);
            end
        end
        pix_step("R3 two-bit mono", 8'h02, 2'd1, 1'b0, 2'd2, 1'b1);
        for (int b = 0; b < 4; b++) pix_step("R4 bank ignored", 8'h5B, 2'd2, 1'b1, 2'(b), 1'b1);
        pix_step("R5 mono four-bit", 8'h0D, 2'd2, 1'b0, 2'd0, 1'b1);
        pix_step("R5 mono eight-bit low nibble", 8'hA7, 2'd3, 1'b0, 2'd3, 1'b1);
        for (int b = 0; b < 4; b++) begin
            pix_step("R6 split 3-3-2", 8'b101_011_10, 2'd3, 1'b1, 2'(b), 1'b1);
            pix_step("R6 split 3-3-2 alt", 8'b010_110_01, 2'd3, 1'b1, 2'(b), 1'b1);
        end
        pix_step("R7 display off colour", 8'hFF, 2'd3, 1'b1, 2'd1, 1'b0);
        pix_step("R7 display off bw", 8'h01, 2'd0, 1'b0, 2'd0, 1'b0);

        // latency: output holds the old value until the next edge
        begin
            logic [11:0] e_a;
            logic [11:0] e_b;
            pix_step("R8 first pixel", 8'h01, 2'd0, 1'b0, 2'd0, 1'b1);
            e_a = exp_rgb(8'h01, 2'd0, 1'b0, 2'd0, 1'b1);
            e_b = exp_rgb(8'h00, 2'd0, 1'b0, 2'd0, 1'b1);
            pix_in = 8'h00;
            #1 chk("R8 no combinational path", 32'({red_o, grn_o, blu_o}), 32'(e_a));
            @(negedge clk);
            chk("R8 one cycle later", 32'({red_o, grn_o, blu_o}), 32'(e_b));
        end

        // constrained random display traffic
        for (int i = 0; i < 1500; i++) begin
            logic [1:0] d;
            logic       c;
            d = 2'($urandom_range(0, 3));
            c = 1'($urandom_range(0, 1));
            pix_step(d == 2'd3 && c ? "R6 random" : (d == 2'd1 ? "R3 random" :
                     (d == 2'd2 ? "R4 random" : "R5 R2 random")),
                     8'($urandom), d, c, 2'($urandom_range(0, 3)),
                     ($urandom_range(0, 9) != 0));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule